// File: doc/BRIEF.md
# Correlator Frame and Update Pulse Generator

This block is the timing heart of a pipelined FX correlator. From one clock it keeps a tick counter for the transform frame (516 ticks: a 512-tick transform plus a 4-tick dead time) and a frame counter for the slow delay-update period (8192 frames). It sends a one-cycle frame-start strobe to each of several downstream units. Each strobe is shifted inside the dead time by that unit's own 0 to 3 tick setting. Once per update period it raises a delay-load strobe on several identical outputs.

A scan begins when the host raises its init request. On the rising edge of that request the block sends a one-cycle init strobe to its consumers. It also restarts both counters, so the first frame and the first update period of the scan begin on the next tick. A synchronous power-on reset puts the block in the same aligned state.

Top module: `corr_sync_gen`

## Requirements
- R1: While `rst` is high, every output is low. The clock edge of the last cycle with `rst` high counts as edge 0 of a fresh frame, the same as an init edge in R3.
- R2: Each frame strobe repeats every FRAME_TICKS (516) cycles while no init edge occurs.
- R3: The edge that samples an init rising edge is edge 0. The strobe of destination i is high in the cycle after edge 513 + d_i, and then after every further 516 edges. That places it on tick 512 + d_i, inside the 4-tick dead time.
- R4: The delay d_i of destination i is the 2-bit field `dest_dly_i[2i+1:2i]`, with a range of 0 to 3. Each field moves only its own destination's strobe.
- R5: Every frame, load and init strobe is exactly one cycle wide.
- R6: All delay-load outputs pulse together, in the same cycle as an undelayed (d = 0) frame strobe. This happens only in frame 0 of each period, so the load repeats every PERIOD_FRAMES × FRAME_TICKS cycles.
- R7: A rising edge of `host_init_i` drives all init outputs high for exactly one cycle, right after the sampling edge. A request held high for several cycles still gives a single strobe.
- R8: An init edge restarts the tick and frame counters. Any frame or load strobe that would have appeared in the init strobe's cycle is suppressed, and later strobes follow R3 and R6 from the new edge 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single timing clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| host_init_i | input | 1 | Host scan-start request (rising edge acts) |
| dest_dly_i | input | N_DEST*DLY_W | Per-destination strobe delay, 2 bits each |
| frame_pulse_o | output | N_DEST | Per-destination frame-start strobes |
| load_pulse_o | output | N_LOAD | Delay-load strobes, one copy per consumer |
| init_pulse_o | output | N_INIT | Scan-start strobes, one copy per consumer |

## Verification
The tick counter can slip or wrap at the wrong value. That moves a frame strobe away from cycle 513 + d, so the error shows within the first frame after an init edge, and a wrong wrap also breaks the 516-cycle spacing one frame later. A fault in the frame counter shows only at the second delay-load of a window, so the bench shortens the update period to three frames. If init fails to clear the counters or fails to suppress strobes, the first cycle after the init edge shows a stray strobe, or the later strobes come out shifted.

// File: rtl/corr_sync_pkg.sv
package corr_sync_pkg;
  localparam int unsigned DEF_FRAME_TICKS   = 516;
  localparam int unsigned DEF_XFORM_TICKS   = 512;
  localparam int unsigned DEF_PERIOD_FRAMES = 8192;

  // Counter width able to hold 0 .. n-1, never below one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/corr_frame_timer.sv
module corr_frame_timer #(
  parameter int unsigned FRAME_TICKS   = 516,
  parameter int unsigned PERIOD_FRAMES = 8192,
  parameter int unsigned TICK_W        = 10,
  parameter int unsigned FRM_W         = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  output logic [TICK_W-1:0] tick_o,
  output logic [FRM_W-1:0]  frame_o
);
  localparam logic [TICK_W-1:0] TICK_LAST  = TICK_W'(FRAME_TICKS - 1);
  localparam logic [FRM_W-1:0]  FRAME_LAST = FRM_W'(PERIOD_FRAMES - 1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      tick_o  <= '0;
      frame_o <= '0;
    end else if (tick_o == TICK_LAST) begin
      tick_o  <= '0;
      frame_o <= (frame_o == FRAME_LAST) ? '0 : frame_o + 1'b1;
    end else begin
      tick_o  <= tick_o + 1'b1;
    end
  end
endmodule

// File: rtl/corr_skew_tap.sv
module corr_skew_tap #(
  parameter int unsigned XFORM_TICKS = 512,
  parameter int unsigned TICK_W      = 10,
  parameter int unsigned DLY_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kill,
  input  logic [TICK_W-1:0] tick_i,
  input  logic [DLY_W-1:0]  dly_i,
  output logic              pulse_o
);
  logic [TICK_W-1:0] target;

  always_comb target = TICK_W'(XFORM_TICKS) + TICK_W'(dly_i);

  always_ff @(posedge clk) begin
    if (rst) pulse_o <= 1'b0;
    else     pulse_o <= !kill && (tick_i == target);
  end
endmodule

// File: rtl/corr_sync_gen.sv
module corr_sync_gen
  import corr_sync_pkg::*;
#(
  parameter int unsigned FRAME_TICKS   = DEF_FRAME_TICKS,
  parameter int unsigned XFORM_TICKS   = DEF_XFORM_TICKS,
  parameter int unsigned PERIOD_FRAMES = DEF_PERIOD_FRAMES,
  parameter int unsigned N_DEST        = 4,
  parameter int unsigned DLY_W         = 2,
  parameter int unsigned N_LOAD        = 4,
  parameter int unsigned N_INIT        = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      host_init_i,
  input  logic [N_DEST*DLY_W-1:0]   dest_dly_i,
  output logic [N_DEST-1:0]         frame_pulse_o,
  output logic [N_LOAD-1:0]         load_pulse_o,
  output logic [N_INIT-1:0]         init_pulse_o
);
  localparam int unsigned TICK_W = cnt_width(FRAME_TICKS);
  localparam int unsigned FRM_W  = cnt_width(PERIOD_FRAMES);

  logic              req_q;
  logic              init_edge;
  logic [TICK_W-1:0] tick;
  logic [FRM_W-1:0]  frame;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= host_init_i;
  end

  always_comb init_edge = host_init_i && !req_q;

  corr_frame_timer #(
    .FRAME_TICKS  (FRAME_TICKS),
    .PERIOD_FRAMES(PERIOD_FRAMES),
    .TICK_W       (TICK_W),
    .FRM_W        (FRM_W)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .restart(init_edge),
    .tick_o (tick),
    .frame_o(frame)
  );

  for (genvar i = 0; i < N_DEST; i++) begin : g_tap
    corr_skew_tap #(
      .XFORM_TICKS(XFORM_TICKS),
      .TICK_W     (TICK_W),
      .DLY_W      (DLY_W)
    ) u_tap (
      .clk    (clk),
      .rst    (rst),
      .kill   (init_edge),
      .tick_i (tick),
      .dly_i  (dest_dly_i[i*DLY_W +: DLY_W]),
      .pulse_o(frame_pulse_o[i])
    );
  end

  // Separate register per consumer copy to keep fan-out local.
  for (genvar j = 0; j < N_LOAD; j++) begin : g_load
    always_ff @(posedge clk) begin
      if (rst) load_pulse_o[j] <= 1'b0;
      else     load_pulse_o[j] <= !init_edge && (frame == '0) &&
                                  (tick == TICK_W'(XFORM_TICKS));
    end
  end

  for (genvar k = 0; k < N_INIT; k++) begin : g_init
    always_ff @(posedge clk) begin
      if (rst) init_pulse_o[k] <= 1'b0;
      else     init_pulse_o[k] <= init_edge;
    end
  end
endmodule

// File: rtl/corr_sync_gen_chk.sv
module corr_sync_gen_chk #(
  parameter int unsigned FRAME_TICKS   = 516,
  parameter int unsigned PERIOD_FRAMES = 8192,
  parameter int unsigned N_DEST        = 4,
  parameter int unsigned N_LOAD        = 4,
  parameter int unsigned N_INIT        = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              host_init_i,
  input logic [N_DEST-1:0] frame_pulse_o,
  input logic [N_LOAD-1:0] load_pulse_o,
  input logic [N_INIT-1:0] init_pulse_o
);
  localparam logic [31:0] LOAD_GAP = 32'(FRAME_TICKS * PERIOD_FRAMES);

  logic [31:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else begin
      gap <= load_pulse_o[0] ? 32'd1 : gap + 32'd1;
      if (init_pulse_o[0])      seen <= 1'b0;
      else if (load_pulse_o[0]) seen <= 1'b1;
    end
  end

  for (genvar i = 0; i < N_DEST; i++) begin : g_fw
    assert_frame_one_wide_R5: assert property (@(posedge clk) disable iff (rst)
      frame_pulse_o[i] |=> !frame_pulse_o[i]);
  end

  assert_load_one_wide_R5: assert property (@(posedge clk) disable iff (rst)
    load_pulse_o[0] |=> !load_pulse_o[0]);

  assert_init_one_wide_R7: assert property (@(posedge clk) disable iff (rst)
    init_pulse_o[0] |=> !init_pulse_o[0]);

  assert_load_copies_R6: assert property (@(posedge clk) disable iff (rst)
    (load_pulse_o == '0) || (load_pulse_o == '1));

  assert_load_spacing_R6: assert property (@(posedge clk) disable iff (rst)
    (load_pulse_o[0] && seen) |-> (gap == LOAD_GAP));

  assert_init_source_R7: assert property (@(posedge clk) disable iff (rst)
    init_pulse_o[0] |-> $past(host_init_i));

  assert_init_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    init_pulse_o[0] |-> (frame_pulse_o == '0) && (load_pulse_o == '0));
endmodule

bind corr_sync_gen corr_sync_gen_chk #(
  .FRAME_TICKS  (FRAME_TICKS),
  .PERIOD_FRAMES(PERIOD_FRAMES),
  .N_DEST       (N_DEST),
  .N_LOAD       (N_LOAD),
  .N_INIT       (N_INIT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_init_i  (host_init_i),
  .frame_pulse_o(frame_pulse_o),
  .load_pulse_o (load_pulse_o),
  .init_pulse_o (init_pulse_o)
);

// File: tb/corr_sync_gen_tb.sv
module corr_sync_gen_tb;
  localparam int FT  = 516;
  localparam int XT  = 512;
  localparam int PF  = 3;
  localparam int WIN = FT * PF + 520;

  // {delay cfg, expected first-strobe edge of dest 3, 2, 1, 0}
  localparam logic [55:0] VEC [4] = '{
    {8'h00, 12'd513, 12'd513, 12'd513, 12'd513},
    {8'hE4, 12'd516, 12'd515, 12'd514, 12'd513},
    {8'h1B, 12'd513, 12'd514, 12'd515, 12'd516},
    {8'hFF, 12'd516, 12'd516, 12'd516, 12'd516}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_init_i = 1'b0;
  logic [7:0] dest_dly_i = 8'h00;
  logic [3:0] frame_pulse_o;
  logic [3:0] load_pulse_o;
  logic [2:0] init_pulse_o;

  int n_chk = 0;
  int n_fail = 0;
  int first_seen [4];

  always #10 clk = ~clk;

  corr_sync_gen #(.PERIOD_FRAMES(PF)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .host_init_i  (host_init_i),
    .dest_dly_i   (dest_dly_i),
    .frame_pulse_o(frame_pulse_o),
    .load_pulse_o (load_pulse_o),
    .init_pulse_o (init_pulse_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts at the sample point after edge 0; walks WIN cycles comparing every output.
  task automatic run_window(input bit exp_init, input string ctx);
    int bad_f [4];
    int act_f [4];
    int exp_f [4];
    int bad_l, act_l, exp_l, bad_i, act_i, exp_i;
    bad_l = -1; bad_i = -1; act_l = 0; exp_l = 0; act_i = 0; exp_i = 0;
    for (int i = 0; i < 4; i++) begin
      bad_f[i] = -1; act_f[i] = 0; exp_f[i] = 0; first_seen[i] = -1;
    end
    for (int c = 0; c < WIN; c++) begin
      logic [3:0] el;
      logic [2:0] ei;
      bit lo;
      lo = (c >= 1) && (((c - 1) % FT) == XT) && ((((c - 1) / FT) % PF) == 0);
      el = {4{lo}};
      ei = {3{exp_init && (c == 0)}};
      for (int i = 0; i < 4; i++) begin
        int d;
        bit ef;
        d  = int'(dest_dly_i[2*i +: 2]);
        ef = (c >= 1) && (((c - 1) % FT) == XT + d);
        if (frame_pulse_o[i] !== ef && bad_f[i] < 0) begin
          bad_f[i] = c; act_f[i] = int'(frame_pulse_o[i]); exp_f[i] = int'(ef);
        end
        if (frame_pulse_o[i] === 1'b1 && first_seen[i] < 0) first_seen[i] = c;
      end
      if (load_pulse_o !== el && bad_l < 0) begin
        bad_l = c; act_l = int'(load_pulse_o); exp_l = int'(el);
      end
      if (init_pulse_o !== ei && bad_i < 0) begin
        bad_i = c; act_i = int'(init_pulse_o); exp_i = int'(ei);
      end
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++)
      chk(bad_f[i] < 0, $sformatf("R2 R3 R4 R5 %s dest%0d strobe at edge %0d", ctx, i, bad_f[i]),
          act_f[i], exp_f[i]);
    chk(bad_l < 0, $sformatf("R6 R5 %s load at edge %0d", ctx, bad_l), act_l, exp_l);
    chk(bad_i < 0, $sformatf("R7 %s init at edge %0d", ctx, bad_i), act_i, exp_i);
  endtask

  task automatic do_init();
    @(negedge clk);
    host_init_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    host_init_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: outputs idle during reset, then timing runs from the last reset edge.
    dest_dly_i = 8'hE4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({frame_pulse_o, load_pulse_o, init_pulse_o} === 11'd0, "R1 outputs low in reset",
        int'({frame_pulse_o, load_pulse_o, init_pulse_o}), 0);
    rst = 1'b0;
    run_window(1'b0, "R1 after reset");

    // Vector table: each delay pattern, aligned by an init edge.
    for (int v = 0; v < 4; v++) begin
      dest_dly_i = VEC[v][55:48];
      do_init();
      run_window(1'b1, $sformatf("vector %0d", v));
      for (int i = 0; i < 4; i++)
        chk(first_seen[i] == int'(VEC[v][12*i +: 12]),
            $sformatf("R3 R4 vector %0d dest%0d first strobe edge", v, i),
            first_seen[i], int'(VEC[v][12*i +: 12]));
    end

    // R7: a request held for five cycles yields one init strobe.
    dest_dly_i = 8'h1B;
    @(negedge clk);
    host_init_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fork
      begin
        repeat (4) @(negedge clk);
        host_init_i = 1'b0;
      end
    join_none
    run_window(1'b1, "R7 held request");

    // R8: init landing on the undelayed strobe tick suppresses it and realigns.
    dest_dly_i = 8'h00;
    do_init();
    repeat (512) @(negedge clk);
    host_init_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    host_init_i = 1'b0;
    chk(frame_pulse_o === 4'h0, "R8 strobe suppressed on init cycle", int'(frame_pulse_o), 0);
    run_window(1'b1, "R8 realigned");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule